// File: doc/BRIEF.md
# Escalating Per-Core Watchdog Timer

This block provides one watchdog per processor core. Software programs a timeout length and an escalation mode into each core's configuration port. Software then services the watchdog by strobing that core's poke input. If a period passes without a poke, the watchdog raises an interrupt. If the next period also passes without a poke, it raises a non-maskable interrupt. One more unserviced period produces a single-cycle chip soft-reset request.

Each period is timed by a down-counter behind a free-running prescaler. The programmed length fills the upper bits of the counter and the lower bits are loaded with ones. A two-bit state output reports the escalation stage. Its bit 1 is set from the NMI stage onward, so a handler can tell a watchdog NMI apart from other NMI sources.

The number of cores is a parameter. Every core has its own configuration, poke strobe and outputs, and no core affects another.

Top module: `wdog_escalate`

## Requirements
- R1: One period lasts (len+1) * 2^(LOW_W+PRE_W) clocks, measured from the configuration write or poke edge to the edge at which the stage advances. With the defaults (LOW_W=8, PRE_W=8) the longest period is 2^32 clocks.
- R2: When the first period expires without a poke, the stage becomes 1 (state code 1) and the interrupt output goes high. The interrupt stays high until a poke, a configuration write or a reset.
- R3: When the second period expires without a poke, the stage becomes 2 (state code 2, state bit 1 set) and the NMI output goes high while the interrupt stays high.
- R4: When the third period expires without a poke, the stage becomes 3 (state code 3) and the soft-reset output pulses high for exactly one clock. The stage then stays 3 with no further pulse until a poke or a configuration write.
- R5: The mode field sets the highest stage that can be reached: 1 = interrupt only, 2 = interrupt and NMI, 3 = the full chain. Once that stage is reached, escalation stops.
- R6: Mode 0 disables the core. While disabled, the state reads 0, all three outputs are low, and a poke has no effect.
- R7: A poke on an enabled core returns the stage to 0 and clears the interrupt and NMI outputs. It also restarts the period from the beginning.
- R8: A configuration write takes the new length and mode. It returns the stage to 0 and restarts both the prescaler and the counter, so the next expiry comes exactly one full period after the write.
- R9: Each core instance is independent. A poke or a configuration write to one core leaves every other core's state and outputs unchanged.
- R10: After reset every core is disabled, with state 0 and all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | N_CORES | Per-core configuration write strobe |
| cfg_len | input | N_CORES*LEN_W | Per-core timeout length; core c uses bits [c*LEN_W +: LEN_W] |
| cfg_mode | input | N_CORES*2 | Per-core escalation mode (0 off, 1 interrupt, 2 up to NMI, 3 up to reset) |
| poke | input | N_CORES | Per-core service strobe |
| wd_state | output | N_CORES*2 | Per-core stage code (0 idle, 1 interrupt, 2 NMI, 3 reset) |
| wd_irq | output | N_CORES | Per-core interrupt level |
| wd_nmi | output | N_CORES | Per-core NMI level |
| wd_srst | output | N_CORES | Per-core single-cycle soft-reset request |

## Verification
The bench samples each stage boundary one cycle before and at the expected expiry edge. An off-by-one in the prescaler or in the counter reload would show up as an early or late stage change. It re-programs a core halfway through a period, which catches a design that fails to reset the prescaler phase and therefore expires a few cycles early. It counts soft-reset pulses over long waits in stage 3, which catches a level output or a pulse that repeats on every later expiry. It also checks that modes 1 and 2 stop escalating at their stage, that a poke to a disabled core does not wake it, and that servicing one core does not disturb another core.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IRQ  = 2'd1,
    ST_NMI  = 2'd2,
    ST_RST  = 2'd3
  } wd_stage_e;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PRE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

  logic [PRE_W-1:0] cnt;

  assign tick = run && !restart && (cnt == PRE_MAX);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount #(
  parameter int LEN_W = 16,
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             tick,
  output logic             expire
);
  localparam int CNT_W = LEN_W + LOW_W;
  localparam logic [LOW_W-1:0] LOW_ONES = {LOW_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  assign expire = tick && !load && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load || expire) begin
      cnt <= {len, LOW_ONES};
    end else if (tick) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              expire,
  input  logic [MODE_W-1:0] mode,
  output wd_stage_e         stage,
  output logic              irq,
  output logic              nmi,
  output logic              srst
);
  wd_stage_e stage_nx;
  logic      enter_rst;

  always_comb begin
    stage_nx  = stage;
    enter_rst = 1'b0;
    if (clear) begin
      stage_nx = ST_IDLE;
    end else if (expire && (MODE_W'(stage) < mode)) begin
      stage_nx  = wd_stage_e'(MODE_W'(stage) + 1'b1);
      enter_rst = (stage == ST_NMI);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= ST_IDLE;
      irq   <= 1'b0;
      nmi   <= 1'b0;
      srst  <= 1'b0;
    end else begin
      stage <= stage_nx;
      irq   <= (stage_nx != ST_IDLE);
      nmi   <= (stage_nx == ST_NMI) || (stage_nx == ST_RST);
      srst  <= enter_rst;
    end
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int LOW_W = 8,
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              poke,
  output logic [1:0]        state,
  output logic              irq,
  output logic              nmi,
  output logic              srst
);
  logic [LEN_W-1:0]  len_q;
  logic [MODE_W-1:0] mode_q;
  logic              enabled;
  logic              restart;
  logic              tick;
  logic              expire;
  logic [LEN_W-1:0]  load_len;
  wd_stage_e         stage;

  assign enabled  = (mode_q != '0);
  assign restart  = cfg_we || (poke && enabled);
  assign load_len = cfg_we ? cfg_len : len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= '0;
      mode_q <= '0;
    end else if (cfg_we) begin
      len_q  <= cfg_len;
      mode_q <= cfg_mode;
    end
  end

  wdog_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (enabled),
    .restart (restart),
    .tick    (tick)
  );

  wdog_downcount #(.LEN_W(LEN_W), .LOW_W(LOW_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load   (restart),
    .len    (load_len),
    .tick   (tick),
    .expire (expire)
  );

  wdog_stage u_stg (
    .clk    (clk),
    .rst    (rst),
    .clear  (restart || !enabled),
    .expire (expire),
    .mode   (mode_q),
    .stage  (stage),
    .irq    (irq),
    .nmi    (nmi),
    .srst   (srst)
  );

  assign state = 2'(stage);
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
  import wdog_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int LEN_W   = 16,
  parameter int LOW_W   = 8,
  parameter int PRE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_CORES-1:0]         cfg_we,
  input  logic [N_CORES*LEN_W-1:0]   cfg_len,
  input  logic [N_CORES*MODE_W-1:0]  cfg_mode,
  input  logic [N_CORES-1:0]         poke,
  output logic [N_CORES*2-1:0]       wd_state,
  output logic [N_CORES-1:0]         wd_irq,
  output logic [N_CORES-1:0]         wd_nmi,
  output logic [N_CORES-1:0]         wd_srst
);
  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    wdog_core #(.LEN_W(LEN_W), .LOW_W(LOW_W), .PRE_W(PRE_W)) u_core (
      .clk      (clk),
      .rst      (rst),
      .cfg_we   (cfg_we[c]),
      .cfg_len  (cfg_len[c*LEN_W +: LEN_W]),
      .cfg_mode (cfg_mode[c*MODE_W +: MODE_W]),
      .poke     (poke[c]),
      .state    (wd_state[c*2 +: 2]),
      .irq      (wd_irq[c]),
      .nmi      (wd_nmi[c]),
      .srst     (wd_srst[c])
    );
  end
endmodule

// File: rtl/wdog_escalate_chk.sv
module wdog_escalate_chk
  import wdog_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int LEN_W   = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic [N_CORES-1:0]        cfg_we,
  input logic [N_CORES*LEN_W-1:0]  cfg_len,
  input logic [N_CORES*MODE_W-1:0] cfg_mode,
  input logic [N_CORES-1:0]        poke,
  input logic [N_CORES*2-1:0]      wd_state,
  input logic [N_CORES-1:0]        wd_irq,
  input logic [N_CORES-1:0]        wd_nmi,
  input logic [N_CORES-1:0]        wd_srst
);
  for (genvar c = 0; c < N_CORES; c++) begin : g_chk
    assert_srst_single_R4: assert property (@(posedge clk) disable iff (rst)
      wd_srst[c] |=> !wd_srst[c]);

    assert_srst_in_rst_stage_R4: assert property (@(posedge clk) disable iff (rst)
      wd_srst[c] |-> (wd_state[c*2 +: 2] == 2'd3));

    assert_nmi_flag_R3: assert property (@(posedge clk) disable iff (rst)
      wd_nmi[c] |-> (wd_state[c*2+1] && wd_irq[c]));

    assert_disable_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      (cfg_we[c] && cfg_mode[c*MODE_W +: MODE_W] == '0) |=>
        (wd_state[c*2 +: 2] == 2'd0 && !wd_irq[c] && !wd_nmi[c] && !wd_srst[c]));

    assert_poke_clears_R7: assert property (@(posedge clk) disable iff (rst)
      (poke[c] && !cfg_we[c]) |=> (wd_state[c*2 +: 2] == 2'd0 && !wd_irq[c]));

    assert_one_step_R2: assert property (@(posedge clk) disable iff (rst)
      (wd_state[c*2 +: 2] == 2'd0) |=> (wd_state[c*2 +: 2] <= 2'd1));
  end
endmodule

bind wdog_escalate wdog_escalate_chk #(.N_CORES(N_CORES), .LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .cfg_len  (cfg_len),
  .cfg_mode (cfg_mode),
  .poke     (poke),
  .wd_state (wd_state),
  .wd_irq   (wd_irq),
  .wd_nmi   (wd_nmi),
  .wd_srst  (wd_srst)
);

// File: tb/sim_wdog_escalate.sv
`timescale 1ns/1ps
module sim_wdog_escalate;
  localparam int N     = 2;
  localparam int LEN_W = 16;
  localparam int LOW_W = 2;
  localparam int PRE_W = 2;
  localparam int NV    = 13;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [N-1:0]       cfg_we = '0;
  logic [N*LEN_W-1:0] cfg_len = '0;
  logic [N*2-1:0]     cfg_mode = '0;
  logic [N-1:0]       poke = '0;
  logic [N*2-1:0]     wd_state;
  logic [N-1:0]       wd_irq, wd_nmi, wd_srst;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdog_escalate #(.N_CORES(N), .LEN_W(LEN_W), .LOW_W(LOW_W), .PRE_W(PRE_W)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_len(cfg_len), .cfg_mode(cfg_mode),
    .poke(poke), .wd_state(wd_state), .wd_irq(wd_irq), .wd_nmi(wd_nmi), .wd_srst(wd_srst)
  );

  // vector: core, len, mode, cycles after write, expected stage
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 16'd0, 2'd3, 16'd15,  2'd0},  // R1 one cycle before expiry
    {1'b0, 16'd0, 2'd3, 16'd16,  2'd1},  // R1 R2 exact expiry
    {1'b0, 16'd0, 2'd3, 16'd31,  2'd1},  // R2
    {1'b0, 16'd0, 2'd3, 16'd32,  2'd2},  // R3
    {1'b0, 16'd0, 2'd3, 16'd48,  2'd3},  // R4
    {1'b0, 16'd0, 2'd3, 16'd80,  2'd3},  // R4 stays, single pulse
    {1'b0, 16'd0, 2'd1, 16'd64,  2'd1},  // R5 mode 1
    {1'b0, 16'd0, 2'd2, 16'd64,  2'd2},  // R5 mode 2
    {1'b1, 16'd1, 2'd3, 16'd31,  2'd0},  // R1 len 1, core 1
    {1'b1, 16'd1, 2'd3, 16'd32,  2'd1},  // R1
    {1'b0, 16'd2, 2'd3, 16'd144, 2'd3},  // R1 R4 len 2
    {1'b0, 16'd0, 2'd0, 16'd64,  2'd0},  // R6 off
    {1'b1, 16'd5, 2'd0, 16'd64,  2'd0}   // R6 off with nonzero len
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int c, input int len, input int mode);
    @(negedge clk);
    cfg_we[c] = 1'b1;
    cfg_len[c*LEN_W +: LEN_W] = LEN_W'(len);
    cfg_mode[c*2 +: 2] = 2'(mode);
    @(posedge clk);
    @(negedge clk);
    cfg_we[c] = 1'b0;
  endtask

  task automatic do_poke(input int c);
    @(negedge clk);
    poke[c] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    poke[c] = 1'b0;
  endtask

  task automatic wait_cyc(input int c, input int n, output int pulses);
    pulses = 0;
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      if (wd_srst[c]) pulses++;
    end
  endtask

  function automatic int st(input int c);
    return int'(wd_state[c*2 +: 2]);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 state", int'(wd_state), 0);
    chk("R10 irq", int'(wd_irq), 0);
    chk("R10 nmi", int'(wd_nmi), 0);
    chk("R10 srst", int'(wd_srst), 0);
    wait_cyc(0, 64, p);
    chk("R10 disabled after reset", st(0) + st(1), 0);

    for (int i = 0; i < NV; i++) begin
      int c, len, mode, cyc, es;
      c    = int'(VEC[i][36]);
      len  = int'(VEC[i][35:20]);
      mode = int'(VEC[i][19:18]);
      cyc  = int'(VEC[i][17:2]);
      es   = int'(VEC[i][1:0]);
      cfg(c, len, mode);
      wait_cyc(c, cyc, p);
      chk($sformatf("R1/R2/R3/R4/R5/R6 vec%0d state", i), st(c), es);
      chk($sformatf("R2 vec%0d irq", i), int'(wd_irq[c]), int'(es >= 1));
      chk($sformatf("R3 vec%0d nmi", i), int'(wd_nmi[c]), int'(es >= 2));
      chk($sformatf("R4 vec%0d srst pulses", i), p, int'(es == 3));
    end

    // R7 poke clears and restarts
    cfg(1, 0, 0);
    cfg(0, 0, 3);
    wait_cyc(0, 20, p);
    chk("R7 pre-poke stage", st(0), 1);
    do_poke(0);
    chk("R7 poke stage", st(0), 0);
    chk("R7 poke irq", int'(wd_irq[0]), 0);
    wait_cyc(0, 15, p);
    chk("R7 restart before expiry", st(0), 0);
    wait_cyc(0, 1, p);
    chk("R7 restart at expiry", st(0), 1);

    // R8 rewrite mid-period restarts prescaler and counter
    cfg(0, 0, 3);
    wait_cyc(0, 10, p);
    cfg(0, 0, 3);
    wait_cyc(0, 15, p);
    chk("R8 rewrite before expiry", st(0), 0);
    wait_cyc(0, 1, p);
    chk("R8 rewrite at expiry", st(0), 1);
    cfg(0, 1, 2);
    wait_cyc(0, 31, p);
    chk("R8 new length before expiry", st(0), 0);
    wait_cyc(0, 1, p);
    chk("R8 new length at expiry", st(0), 1);

    // R6 disable while escalated, poke ignored
    cfg(0, 0, 3);
    wait_cyc(0, 20, p);
    cfg(0, 0, 0);
    chk("R6 disable clears stage", st(0), 0);
    chk("R6 disable clears irq", int'(wd_irq[0]), 0);
    do_poke(0);
    wait_cyc(0, 64, p);
    chk("R6 poke on disabled", st(0), 0);
    chk("R6 disabled irq", int'(wd_irq[0]), 0);

    // R9 independence
    cfg(1, 0, 3);
    wait_cyc(1, 40, p);
    chk("R9 core1 stage", st(1), 2);
    chk("R9 core0 untouched", st(0), 0);
    cfg(0, 0, 3);
    do_poke(0);
    chk("R9 core1 after core0 access", st(1), 2);
    chk("R9 core1 nmi kept", int'(wd_nmi[1]), 1);

    // R10 reset mid-escalation
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10 mid-run reset state", int'(wd_state), 0);
    chk("R10 mid-run reset nmi", int'(wd_nmi), 0);
    wait_cyc(1, 64, p);
    chk("R10 disabled after mid-run reset", int'(wd_state), 0);

    finish_run();
  end
endmodule